// File: doc/BRIEF.md
# Stack Pointer and Call/Return Unit

This block owns the stack pointer of a 16-bit, byte-addressed core and carries out the four stack-based operations: push a data word, pop a data word, call a subroutine and return from one. It also accepts a direct overwrite of the stack pointer. All memory traffic goes through a single-port, word-wide memory port. That port has an address, write data, a one-cycle-latency read data input, a write strobe and per-byte lane enables.

The stack grows downward. The pointer always names the most recently stored item, so a push moves the pointer first and then stores, and a pop fetches first and then moves the pointer. A pop leaves memory untouched. A call stores the return address supplied by the core and then moves the program counter to the subroutine entry. A return loads the program counter from the top item. Every stack operation is accepted only while the unit is idle and then keeps it busy for two cycles. A pointer overwrite completes at the edge that accepts it.

Top module: `call_stack_unit`

## Requirements
- R1: After reset the stack pointer equals the parameter SP_RESET (default 0x0200), the program counter equals PC_RESET (default 0x0000), and busy, pc_load, pop_valid, odd_err and conflict_err are all 0.
- R2: A word push lowers the stack pointer by 2 in its first busy cycle. In its second busy cycle it writes the pushed word at the new pointer with mem_be = 2'b11. The final pointer is the old pointer minus 2.
- R3: A byte push (push_byte = 1) takes a full 2-byte slot like a word push. It writes with mem_be = 2'b01, so only bits 7:0 at the new pointer change and the upper byte of that slot keeps its previous memory contents.
- R4: A pop reads the word at the current pointer, returns it on pop_data with a one-cycle pop_valid pulse, and leaves the pointer 2 higher. Memory is not written, so reloading the old pointer and popping again returns the same word.
- R5: A call writes call_next at pointer minus 2 as a full word and loads the program counter with call_target. pc_load pulses for one cycle. The program counter changes only in a cycle where pc_load is 1.
- R6: A return loads the program counter with the word at the current pointer, raises pc_load for one cycle and leaves the pointer 2 higher.
- R7: A pointer load takes effect at the accepting edge with bit 0 forced to 0. If load_value bit 0 is 1, odd_err is 1 for exactly the next cycle. A load never makes the unit busy.
- R8: A push, pop, call or return holds busy at 1 for exactly two cycles. A request that arrives while busy is 1 is dropped with no effect on pointer, memory, program counter or outputs.
- R9: If more than one of push_req, pop_req, call_req, ret_req and load_req is 1 in an idle cycle, none is performed. conflict_err is then 1 for exactly the next cycle and busy stays 0.
- R10: Over any mix of operations the data leave in last-in, first-out order, so each pop or return yields the value most recently stored in the slot at the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_req | input | 1 | Request a data push |
| pop_req | input | 1 | Request a data pop |
| call_req | input | 1 | Request a subroutine call |
| ret_req | input | 1 | Request a subroutine return |
| load_req | input | 1 | Request a direct stack pointer overwrite |
| push_data | input | 16 | Word to push |
| push_byte | input | 1 | Push only the low byte lane |
| load_value | input | 16 | New stack pointer value |
| call_target | input | 16 | Subroutine entry address |
| call_next | input | 16 | Address of the instruction following the call |
| sp | output | 16 | Current stack pointer (bit 0 always 0) |
| pc | output | 16 | Program counter as set by call and return |
| pc_load | output | 1 | One-cycle pulse when pc takes a new value |
| pop_data | output | 16 | Word returned by the last pop |
| pop_valid | output | 1 | One-cycle pulse when pop_data is fresh |
| busy | output | 1 | A stack operation is in progress |
| odd_err | output | 1 | One-cycle pulse after an odd pointer load |
| conflict_err | output | 1 | One-cycle pulse after simultaneous requests |
| mem_addr | output | 16 | Memory byte address, always even |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 2 | Memory byte lane enables |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |

## Verification
Two kinds of overlap can happen in one cycle. In the first, a push and a pop are both requested from idle, or another pair of requests is. The bench drives such pairs directly and expects a conflict pulse with pointer, memory and busy unchanged. In the second, a new request lands in the middle of an operation already running. The bench raises a pop during the first busy cycle of a push and expects exactly the push's result, with no pop_valid pulse and an unchanged pointer afterward. A seeded random mix of pushes, byte pushes, pops, calls, returns and even loads is then compared against a shadow copy of the memory kept by the bench.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ONE  = 2'd1,
    PH_TWO  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } stk_op_e;

  localparam int NUM_REQ = 5;

  function automatic logic op_stores(input stk_op_e op);
    return (op == OP_PUSH) || (op == OP_CALL);
  endfunction

endpackage

// File: rtl/stk_req_arb.sv
module stk_req_arb
  import stk_pkg::*;
(
  input  logic    idle,
  input  logic    push_req,
  input  logic    pop_req,
  input  logic    call_req,
  input  logic    ret_req,
  input  logic    load_req,
  output logic    start,
  output stk_op_e op,
  output logic    load_go,
  output logic    conflict
);

  localparam int CNT_W = $clog2(NUM_REQ + 1);

  logic [NUM_REQ-1:0] req_vec;
  logic [CNT_W-1:0]   req_cnt;
  logic               single;

  assign req_vec = {load_req, ret_req, call_req, pop_req, push_req};

  always_comb begin
    req_cnt = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      req_cnt = req_cnt + CNT_W'(req_vec[i]);
    end
  end

  assign single   = (req_cnt == CNT_W'(1));
  assign conflict = idle && (req_cnt > CNT_W'(1));
  assign load_go  = idle && single && load_req;
  assign start    = idle && single && !load_req;

  always_comb begin
    if (pop_req)       op = OP_POP;
    else if (call_req) op = OP_CALL;
    else if (ret_req)  op = OP_RET;
    else               op = OP_PUSH;
  end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int W = 16
)
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  stk_op_e      op_in,
  input  logic [W-1:0] wdata_in,
  input  logic         byte_in,
  output logic         busy,
  output logic         sp_dec,
  output logic         sp_inc,
  output logic         mem_we,
  output logic         byte_o,
  output logic [W-1:0] wdata_o,
  output logic         fin_pop,
  output logic         fin_call,
  output logic         fin_ret
);

  phase_e        phase_q, phase_d;
  stk_op_e       op_q;
  logic [W-1:0]  wdata_q;
  logic          byte_q;
  logic          stores;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: if (start) phase_d = PH_ONE;
      PH_ONE:  phase_d = PH_TWO;
      PH_TWO:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      op_q    <= OP_PUSH;
      wdata_q <= '0;
      byte_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (start) begin
        op_q    <= op_in;
        wdata_q <= wdata_in;
        byte_q  <= byte_in;
      end
    end
  end

  assign stores   = op_stores(op_q);
  assign busy     = (phase_q != PH_IDLE);
  assign sp_dec   = (phase_q == PH_ONE) && stores;
  assign sp_inc   = (phase_q == PH_TWO) && !stores;
  assign mem_we   = (phase_q == PH_TWO) && stores;
  assign byte_o   = byte_q;
  assign wdata_o  = wdata_q;
  assign fin_pop  = (phase_q == PH_TWO) && (op_q == OP_POP);
  assign fin_call = (phase_q == PH_TWO) && (op_q == OP_CALL);
  assign fin_ret  = (phase_q == PH_TWO) && (op_q == OP_RET);

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int          W     = 16,
  parameter logic [W-1:0] RESET = 16'h0200
)
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  input  logic         inc,
  output logic [W-1:0] sp,
  output logic         odd_err
);

  localparam int HI_W = W - 1;

  logic [HI_W-1:0] hi_q, hi_d;
  logic            hi_en;
  logic            odd_q;

  always_comb begin
    hi_d  = hi_q;
    hi_en = load_en || dec || inc;
    if (load_en)  hi_d = load_val[W-1:1];
    else if (dec) hi_d = hi_q - HI_W'(1);
    else if (inc) hi_d = hi_q + HI_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= RESET[W-1:1];
      odd_q <= 1'b0;
    end else begin
      if (hi_en) hi_q <= hi_d;
      odd_q <= load_en && load_val[0];
    end
  end

  assign sp      = {hi_q, 1'b0};
  assign odd_err = odd_q;

endmodule

// File: rtl/call_stack_unit.sv
module call_stack_unit
  import stk_pkg::*;
#(
  parameter int           DATA_W   = 16,
  parameter logic [15:0]  SP_RESET = 16'h0200,
  parameter logic [15:0]  PC_RESET = 16'h0000
)
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push_req,
  input  logic                  pop_req,
  input  logic                  call_req,
  input  logic                  ret_req,
  input  logic                  load_req,
  input  logic [DATA_W-1:0]     push_data,
  input  logic                  push_byte,
  input  logic [DATA_W-1:0]     load_value,
  input  logic [DATA_W-1:0]     call_target,
  input  logic [DATA_W-1:0]     call_next,
  output logic [DATA_W-1:0]     sp,
  output logic [DATA_W-1:0]     pc,
  output logic                  pc_load,
  output logic [DATA_W-1:0]     pop_data,
  output logic                  pop_valid,
  output logic                  busy,
  output logic                  odd_err,
  output logic                  conflict_err,
  output logic [DATA_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic                  mem_we,
  output logic [DATA_W/8-1:0]   mem_be,
  input  logic [DATA_W-1:0]     mem_rdata
);

  localparam int BE_W = DATA_W / 8;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic          start, load_go, conflict;
  stk_op_e       op_sel;
  logic          sp_dec, sp_inc, seq_we, seq_byte;
  logic [DATA_W-1:0] seq_wdata, wdata_sel;
  logic          fin_pop, fin_call, fin_ret;
  logic          byte_sel;

  stk_req_arb u_arb (
    .idle     (!busy),
    .push_req (push_req),
    .pop_req  (pop_req),
    .call_req (call_req),
    .ret_req  (ret_req),
    .load_req (load_req),
    .start    (start),
    .op       (op_sel),
    .load_go  (load_go),
    .conflict (conflict)
  );

  assign wdata_sel = (op_sel == OP_CALL) ? call_next : push_data;
  assign byte_sel  = (op_sel == OP_PUSH) && push_byte;

  stk_seq #(.W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .op_in    (op_sel),
    .wdata_in (wdata_sel),
    .byte_in  (byte_sel),
    .busy     (busy),
    .sp_dec   (sp_dec),
    .sp_inc   (sp_inc),
    .mem_we   (seq_we),
    .byte_o   (seq_byte),
    .wdata_o  (seq_wdata),
    .fin_pop  (fin_pop),
    .fin_call (fin_call),
    .fin_ret  (fin_ret)
  );

  stk_ptr #(.W(DATA_W), .RESET(SP_RESET[DATA_W-1:0])) u_ptr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_en  (load_go),
    .load_val (load_value),
    .dec      (sp_dec),
    .inc      (sp_inc),
    .sp       (sp),
    .odd_err  (odd_err)
  );

  // memory port: address tracks the pointer in every phase
  assign mem_addr  = sp;
  assign mem_wdata = seq_wdata;
  assign mem_we    = seq_we;

  generate
    if (BE_W > 1) begin : g_multi_lane
      assign mem_be = seq_byte ? {{(BE_W-1){1'b0}}, 1'b1} : {BE_W{1'b1}};
    end else begin : g_single_lane
      assign mem_be = 1'b1;
    end
  endgenerate

  // program counter, pop result and error pulse registers
  logic [DATA_W-1:0] pc_q, pc_d, target_q, pop_data_q;
  logic              pc_en, pc_load_q, pop_valid_q, conflict_q;

  always_comb begin
    pc_en = fin_call || fin_ret;
    pc_d  = fin_call ? target_q : mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q        <= PC_RESET[DATA_W-1:0];
      target_q    <= '0;
      pop_data_q  <= '0;
      pc_load_q   <= 1'b0;
      pop_valid_q <= 1'b0;
      conflict_q  <= 1'b0;
    end else begin
      if (pc_en) pc_q <= pc_d;
      if (start && (op_sel == OP_CALL)) target_q <= call_target;
      if (fin_pop) pop_data_q <= mem_rdata;
      pc_load_q   <= pc_en;
      pop_valid_q <= fin_pop;
      conflict_q  <= conflict;
    end
  end

  assign pc           = pc_q;
  assign pc_load      = pc_load_q;
  assign pop_data     = pop_data_q;
  assign pop_valid    = pop_valid_q;
  assign conflict_err = conflict_q;

endmodule

// File: rtl/stk_checks.sv
module stk_checks #(
  parameter int W = 16
)
(
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] sp,
  input logic [W-1:0] pc,
  input logic         pc_load,
  input logic         busy,
  input logic         mem_we,
  input logic [W/8-1:0] mem_be,
  input logic         pop_valid,
  input logic         odd_err,
  input logic         conflict_err
);

  // write lands on the slot after the pointer already moved down
  assert_write_after_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(sp) == sp + W'(2)));

  assert_write_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_be != '0));

  assert_pop_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> (sp == $past(sp) + W'(2)));

  assert_pc_moves_with_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != $past(pc)) |-> pc_load);

  assert_load_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    odd_err |-> !busy);

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  assert_busy_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy);

  assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_conflict_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_err |-> !busy);

endmodule

bind call_stack_unit stk_checks #(.W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sp           (sp),
  .pc           (pc),
  .pc_load      (pc_load),
  .busy         (busy),
  .mem_we       (mem_we),
  .mem_be       (mem_be),
  .pop_valid    (pop_valid),
  .odd_err      (odd_err),
  .conflict_err (conflict_err)
);

// File: tb/call_stack_unit_test.sv
`timescale 1ns/1ps
module call_stack_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_req = 0, pop_req = 0, call_req = 0, ret_req = 0, load_req = 0;
  logic [15:0] push_data = 0, load_value = 0, call_target = 0, call_next = 0;
  logic        push_byte = 0;
  logic [15:0] sp, pc, pop_data, mem_addr, mem_wdata;
  logic [15:0] mem_rdata;
  logic        pc_load, pop_valid, busy, odd_err, conflict_err, mem_we;
  logic [1:0]  mem_be;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] ram    [256];
  logic [15:0] shadow [256];
  logic [15:0] exp_sp;
  logic [15:0] exp_pc;

  always #10 clk = ~clk;

  call_stack_unit uut (
    .clk(clk), .rst_n(rst_n),
    .push_req(push_req), .pop_req(pop_req), .call_req(call_req),
    .ret_req(ret_req), .load_req(load_req),
    .push_data(push_data), .push_byte(push_byte), .load_value(load_value),
    .call_target(call_target), .call_next(call_next),
    .sp(sp), .pc(pc), .pc_load(pc_load), .pop_data(pop_data),
    .pop_valid(pop_valid), .busy(busy), .odd_err(odd_err),
    .conflict_err(conflict_err),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_be(mem_be), .mem_rdata(mem_rdata)
  );

  // bench memory, synchronous read
  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_be[0]) ram[mem_addr[8:1]][7:0]  <= mem_wdata[7:0];
      if (mem_be[1]) ram[mem_addr[8:1]][15:8] <= mem_wdata[15:8];
    end
    mem_rdata <= ram[mem_addr[8:1]];
  end

  function automatic logic [15:0] seed_word(input int i);
    return 16'(i * 16'h0101) ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                        input logic bytef);
    return bytef ? {old[15:8], nw[7:0]} : nw;
  endfunction

  function automatic logic [7:0] slot(input logic [15:0] a);
    return a[8:1];
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clear_reqs();
    push_req = 0; pop_req = 0; call_req = 0; ret_req = 0; load_req = 0;
  endtask

  task automatic do_push(input logic [15:0] d, input logic bytef);
    logic [15:0] ns;
    @(negedge clk);
    push_req = 1; push_data = d; push_byte = bytef;
    @(negedge clk);
    clear_reqs();
    chk("R8 busy first cycle", {15'd0, busy}, 16'd1);
    @(negedge clk);
    chk("R2 write strobe", {15'd0, mem_we}, 16'd1);
    chk(bytef ? "R3 byte lanes" : "R2 word lanes", {14'd0, mem_be}, bytef ? 16'd1 : 16'd3);
    ns = exp_sp - 16'd2;
    chk("R2 address after decrement", mem_addr, ns);
    @(negedge clk);
    exp_sp = ns;
    shadow[slot(ns)] = merge(shadow[slot(ns)], d, bytef);
    chk("R2 pointer after push", sp, exp_sp);
    chk("R8 idle after two cycles", {15'd0, busy}, 16'd0);
  endtask

  task automatic do_pop();
    @(negedge clk);
    pop_req = 1;
    @(negedge clk);
    clear_reqs();
    @(negedge clk);
    @(negedge clk);
    chk("R4 pop_valid pulse", {15'd0, pop_valid}, 16'd1);
    chk("R10 popped word", pop_data, shadow[slot(exp_sp)]);
    exp_sp = exp_sp + 16'd2;
    chk("R4 pointer after pop", sp, exp_sp);
  endtask

  task automatic do_call(input logic [15:0] tgt, input logic [15:0] nxt);
    @(negedge clk);
    call_req = 1; call_target = tgt; call_next = nxt;
    @(negedge clk);
    clear_reqs();
    @(negedge clk);
    chk("R5 return address write", mem_wdata, nxt);
    @(negedge clk);
    exp_sp = exp_sp - 16'd2;
    shadow[slot(exp_sp)] = nxt;
    exp_pc = tgt;
    chk("R5 pc at entry", pc, exp_pc);
    chk("R5 pc_load pulse", {15'd0, pc_load}, 16'd1);
    chk("R5 pointer after call", sp, exp_sp);
  endtask

  task automatic do_ret();
    @(negedge clk);
    ret_req = 1;
    @(negedge clk);
    clear_reqs();
    @(negedge clk);
    @(negedge clk);
    exp_pc = shadow[slot(exp_sp)];
    exp_sp = exp_sp + 16'd2;
    chk("R6 pc restored", pc, exp_pc);
    chk("R6 pc_load pulse", {15'd0, pc_load}, 16'd1);
    chk("R6 pointer after return", sp, exp_sp);
  endtask

  task automatic do_load(input logic [15:0] v);
    @(negedge clk);
    load_req = 1; load_value = v;
    @(negedge clk);
    clear_reqs();
    exp_sp = {v[15:1], 1'b0};
    chk("R7 loaded pointer", sp, exp_sp);
    chk("R7 odd flag", {15'd0, odd_err}, {15'd0, v[0]});
    chk("R7 load not busy", {15'd0, busy}, 16'd0);
    @(negedge clk);
    chk("R7 odd flag one cycle", {15'd0, odd_err}, 16'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] keep_sp, keep_word;
    for (int i = 0; i < 256; i++) begin
      ram[i] = seed_word(i);
      shadow[i] = seed_word(i);
    end
    exp_sp = 16'h0200;
    exp_pc = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 reset pointer", sp, 16'h0200);
    chk("R1 reset pc", pc, 16'h0000);
    chk("R1 reset flags", {11'd0, busy, pc_load, pop_valid, odd_err, conflict_err}, 16'd0);

    // R2/R4 word push then pop
    do_push(16'hBEEF, 1'b0);
    do_push(16'h1234, 1'b0);
    do_pop();
    do_pop();

    // R3 byte push keeps upper byte of slot
    do_push(16'hA5C3, 1'b1);
    do_pop();

    // R5/R6 call at F248h, next F24Ah, entry E400h
    do_call(16'hE400, 16'hF24A);
    do_ret();
    chk("R6 resumes after call", pc, 16'hF24A);

    // R4 pop leaves memory intact
    do_push(16'h7E57, 1'b0);
    keep_sp = exp_sp;
    do_pop();
    keep_word = pop_data;
    do_load(keep_sp);
    do_pop();
    chk("R4 word survives pop", pop_data, keep_word);

    // R7 odd load
    do_load(16'h0321);
    do_load(16'h0200);

    // R9 push and pop at once
    @(negedge clk);
    push_req = 1; pop_req = 1; push_data = 16'hDEAD;
    @(negedge clk);
    clear_reqs();
    chk("R9 conflict pulse", {15'd0, conflict_err}, 16'd1);
    chk("R9 stays idle", {15'd0, busy}, 16'd0);
    chk("R9 pointer unchanged", sp, exp_sp);
    @(negedge clk);
    chk("R9 conflict one cycle", {15'd0, conflict_err}, 16'd0);
    chk("R9 pointer still unchanged", sp, exp_sp);

    // R9 load and call at once
    @(negedge clk);
    load_req = 1; call_req = 1; load_value = 16'h0100; call_target = 16'h1111;
    @(negedge clk);
    clear_reqs();
    chk("R9 load/call conflict", {15'd0, conflict_err}, 16'd1);
    repeat (3) @(negedge clk);
    chk("R9 no pc change", pc, exp_pc);
    chk("R9 no pointer change", sp, exp_sp);

    // R8 request during busy is dropped
    @(negedge clk);
    push_req = 1; push_data = 16'h4444; push_byte = 0;
    @(negedge clk);
    push_req = 0; pop_req = 1;
    @(negedge clk);
    pop_req = 0;
    @(negedge clk);
    exp_sp = exp_sp - 16'd2;
    shadow[slot(exp_sp)] = 16'h4444;
    chk("R8 push completed alone", sp, exp_sp);
    repeat (3) begin
      @(negedge clk);
      chk("R8 dropped pop no pulse", {15'd0, pop_valid}, 16'd0);
    end
    chk("R8 pointer after drop", sp, exp_sp);

    // R10 seeded random mix
    begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'h00C0FFEE);
    end
    for (int n = 0; n < 400; n++) begin
      int unsigned pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0, 1, 2: do_push(16'($urandom), 1'b0);
        3:       do_push(16'($urandom), 1'b1);
        4, 5, 6: do_pop();
        7:       do_call(16'($urandom), 16'($urandom));
        8:       do_ret();
        default: do_load({7'b0000001, 8'($urandom), 1'b0});
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule